// File: doc/BRIEF.md
# Keyed Write-Guard for a Mode-Control Bit

This block keeps a single mode-control bit safe from stray or runaway bus writes. It sits on a simple synchronous register bus: an address, write data, a write strobe and combinational read data. It decodes three locations. The first is a write-only key register. The second holds the guarded mode bit. The third is a status register with sticky error flags.

The mode bit changes only through a fixed unlock sequence. Software first writes the key byte. It then makes three writes to the mode location: the wanted value, its inverse, and the wanted value again. Only that last write lands. Any write that breaks the pattern abandons the attempt, leaves the bit alone and raises a protection-error flag. Two further flags record programming errors signalled by external pulse inputs. Software clears each flag by writing 0 to it.

Top module: `prot_mode_guard`

## Requirements
- R1: After reset the mode bit reads 0 and the status register reads 8'h00.
- R2: A key write of 8'hA5 to address 0, followed by writes to address 1 carrying bit-0 values v, ~v and v, sets the mode bit to v on the third of those writes. The mode location reads {7'b0, mode}, and `mode_o` carries the same bit.
- R3: The first and second mode-location writes of a sequence leave the mode bit unchanged.
- R4: A mode-location write while no sequence is armed leaves the mode bit unchanged and sets status bit 0.
- R5: A wrong inverse (bit 0 not the complement of the first value) or a wrong final value leaves the mode bit unchanged. It also sets status bit 0 and ends the attempt, so a further mode write is again unarmed.
- R6: A completed sequence re-locks the bit. The next mode write needs a fresh key.
- R7: A key write of 8'hA5 during a sequence restarts it at the armed point without an error. A key write of any other value drops the attempt without an error.
- R8: A high level on `prog_err_a_i` or `prog_err_b_i` at a clock edge sets status bit 1 or status bit 2 respectively.
- R9: A write to the status register (address 2) clears each flag whose data bit is 0 and leaves flags whose data bit is 1 as they were. A set event in the same cycle wins over a clear.
- R10: The key register reads 0, and status bits 7..3 read 0. Writes to the status register or to unused addresses in mid-sequence neither break nor advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| prog_err_a_i | input | 1 | Sets status bit 1 |
| prog_err_b_i | input | 1 | Sets status bit 2 |
| mode_o | output | 1 | Guarded mode bit |

## Verification
The bench targets the points where a careless sequencer goes wrong. A design that commits on the first or second mode write would show the new bit too early. A design that stays unlocked after a commit would accept a lone follow-up write with no error. A design that compares the inverse loosely would commit on a value-value-value pattern. The bench also checks that a repeated key restarts the sequence instead of flagging an error, that writing 1 to a status flag never sets or clears it, and that an external error pulse arriving in the same cycle as a clearing write still leaves its flag set.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_KEYED   = 2'd1,
    SQ_VALUE   = 2'd2,
    SQ_INVERSE = 2'd3
  } seq_state_t;

  // Second write of a sequence must carry the complement of the first.
  function automatic logic inverse_ok(input logic latched, input logic incoming);
    return incoming == ~latched;
  endfunction

  // Sticky flag update: a written 0 clears, a written 1 keeps; sets dominate.
  function automatic logic [2:0] flag_next(input logic [2:0] cur,
                                           input logic       wr,
                                           input logic [2:0] wmask,
                                           input logic [2:0] set);
    logic [2:0] kept;
    kept = wr ? (cur & wmask) : cur;
    return kept | set;
  endfunction

endpackage

// File: rtl/wlk_decode.sv
module wlk_decode #(
  parameter int AW        = 4,
  parameter int KEY_ADDR  = 0,
  parameter int MODE_ADDR = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  output logic          hit_key,
  output logic          hit_mode,
  output logic          hit_stat,
  output logic          wr_key,
  output logic          wr_mode,
  output logic          wr_stat
);
  localparam logic [AW-1:0] A_KEY  = AW'(KEY_ADDR);
  localparam logic [AW-1:0] A_MODE = AW'(MODE_ADDR);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);

  assign hit_key  = (addr == A_KEY);
  assign hit_mode = (addr == A_MODE);
  assign hit_stat = (addr == A_STAT);
  assign wr_key   = we && hit_key;
  assign wr_mode  = we && hit_mode;
  assign wr_stat  = we && hit_stat;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_key, wr_mode, wr_stat}));
endmodule

// File: rtl/wlk_seq.sv
module wlk_seq
  import wlk_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] KEY_VALUE = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_key,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  output logic          commit_evt,
  output logic          commit_val,
  output logic          prot_err_evt,
  output seq_state_t    state_o
);
  seq_state_t st, st_nxt;
  logic       lat_q;
  logic       key_match;
  logic       in_bit;

  assign key_match = (wdata == KEY_VALUE);
  assign in_bit    = wdata[0];

  always_comb begin
    st_nxt       = st;
    commit_evt   = 1'b0;
    prot_err_evt = 1'b0;
    if (wr_key) begin
      st_nxt = key_match ? SQ_KEYED : SQ_IDLE;
    end else if (wr_mode) begin
      unique case (st)
        SQ_IDLE:  prot_err_evt = 1'b1;
        SQ_KEYED: st_nxt = SQ_VALUE;
        SQ_VALUE: begin
          if (inverse_ok(lat_q, in_bit)) begin
            st_nxt = SQ_INVERSE;
          end else begin
            st_nxt       = SQ_IDLE;
            prot_err_evt = 1'b1;
          end
        end
        SQ_INVERSE: begin
          st_nxt = SQ_IDLE;
          if (in_bit == lat_q) commit_evt   = 1'b1;
          else                 prot_err_evt = 1'b1;
        end
        default: st_nxt = SQ_IDLE;
      endcase
    end
  end

  assign commit_val = lat_q;
  assign state_o    = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      lat_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (wr_mode && !wr_key && st == SQ_KEYED) lat_q <= in_bit;
    end
  end

  assert_key_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && key_match) |=> (st == SQ_KEYED));
  assert_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (st == SQ_IDLE));
  assert_unarmed_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && st == SQ_IDLE) |-> (prot_err_evt && !commit_evt));
  assert_err_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_evt |=> (st == SQ_IDLE));
endmodule

// File: rtl/wlk_status.sv
module wlk_status
  import wlk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic [2:0] wmask,
  input  logic       prot_err_evt,
  input  logic       ext_err_a,
  input  logic       ext_err_b,
  output logic [2:0] flags
);
  logic [2:0] set_vec;
  assign set_vec = {ext_err_b, ext_err_a, prot_err_evt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 3'b000;
    else        flags <= flag_next(flags, wr_stat, wmask, set_vec);
  end

  assert_ext_a_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_err_a |=> flags[1]);
  assert_ext_b_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_err_b |=> flags[2]);
  assert_one_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wmask[0] && flags[0]) |=> flags[0]);
  assert_err_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[0] && !prot_err_evt) |=> !flags[0]);
endmodule

// File: rtl/prot_mode_guard.sv
module prot_mode_guard
  import wlk_pkg::*;
#(
  parameter int            AW        = 4,
  parameter int            DW        = 8,
  parameter int            KEY_ADDR  = 0,
  parameter int            MODE_ADDR = 1,
  parameter int            STAT_ADDR = 2,
  parameter logic [DW-1:0] KEY_VALUE = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  input  logic          prog_err_a_i,
  input  logic          prog_err_b_i,
  output logic          mode_o
);
  localparam int NFLAG = 3;

  logic       hit_key, hit_mode, hit_stat;
  logic       wr_key, wr_mode, wr_stat;
  logic       commit_evt, commit_val, prot_err_evt;
  seq_state_t seq_state;
  logic [NFLAG-1:0] flags;
  logic       mode_q;

  wlk_decode #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)
  ) i_decode (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .hit_key(hit_key), .hit_mode(hit_mode), .hit_stat(hit_stat),
    .wr_key(wr_key), .wr_mode(wr_mode), .wr_stat(wr_stat)
  );

  wlk_seq #(.DW(DW), .KEY_VALUE(KEY_VALUE)) i_seq (
    .clk(clk), .rst_n(rst_n), .wr_key(wr_key), .wr_mode(wr_mode),
    .wdata(bus_wdata), .commit_evt(commit_evt), .commit_val(commit_val),
    .prot_err_evt(prot_err_evt), .state_o(seq_state)
  );

  wlk_status i_status (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat),
    .wmask(bus_wdata[NFLAG-1:0]), .prot_err_evt(prot_err_evt),
    .ext_err_a(prog_err_a_i), .ext_err_b(prog_err_b_i), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= 1'b0;
    else if (commit_evt) mode_q <= commit_val;
  end

  assign mode_o = mode_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_mode)      bus_rdata = {{(DW-1){1'b0}}, mode_q};
    else if (hit_stat) bus_rdata = {{(DW-NFLAG){1'b0}}, flags};
  end

  assert_mode_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(mode_q));
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err_evt |=> flags[0]);
  assert_commit_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (mode_o == $past(bus_wdata[0])));
  assert_no_commit_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_evt && prot_err_evt));
endmodule

// File: tb/test_prot_mode_guard.sv
module test_prot_mode_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       ea = 1'b0, eb = 1'b0;
  logic       mode_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  prot_mode_guard i_prot_mode_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .prog_err_a_i(ea),
    .prog_err_b_i(eb), .mode_o(mode_o)
  );

  always #5 clk = ~clk;

  // Behavioural reference: step counter plus plain bits.
  int       m_step = 0;
  bit       m_val = 0;
  bit       m_mode = 0;
  bit [2:0] m_flag = 0;

  always @(posedge clk) begin
    bit e;
    e = 0;
    if (!rst_n) begin
      m_step = 0; m_val = 0; m_mode = 0; m_flag = 0;
    end else begin
      if (bus_we) begin
        if (bus_addr == 4'd0) m_step = (bus_wdata == 8'hA5) ? 1 : 0;
        else if (bus_addr == 4'd1) begin
          if (m_step == 0) e = 1;
          else if (m_step == 1) begin m_val = bus_wdata[0]; m_step = 2; end
          else if (m_step == 2) begin
            if (bus_wdata[0] != m_val) m_step = 3;
            else begin e = 1; m_step = 0; end
          end else begin
            if (bus_wdata[0] == m_val) m_mode = m_val; else e = 1;
            m_step = 0;
          end
        end else if (bus_addr == 4'd2) m_flag = m_flag & bus_wdata[2:0];
      end
      m_flag = m_flag | {eb, ea, e};
    end
  end

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a == 4'd1) return {7'b0, m_mode};
    if (a == 4'd2) return {5'b0, m_flag};
    return 8'h00;
  endfunction

  // Per-clock comparison, 2 ns after the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      total++;
      if (bus_rdata !== m_read(bus_addr) || mode_o !== m_mode) begin
        bad++;
        $display("FAIL R10 model compare addr=%0d got=%h/%b exp=%h/%b",
                 bus_addr, bus_rdata, mode_o, m_read(bus_addr), m_mode);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input bit which_b, input bit with_clr);
    @(negedge clk);
    if (which_b) eb = 1'b1; else ea = 1'b1;
    if (with_clr) begin bus_addr = 4'd2; bus_wdata = 8'h00; bus_we = 1'b1; end
    @(negedge clk);
    ea = 1'b0; eb = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'd1, r); chk("R1 mode after reset", r, 8'h00);
    rd(4'd2, r); chk("R1 status after reset", r, 8'h00);

    wr(4'd0, 8'hA5); wr(4'd1, 8'h01);
    rd(4'd1, r); chk("R3 after first write", r, 8'h00);
    wr(4'd1, 8'hFE);
    rd(4'd1, r); chk("R3 after inverse write", r, 8'h00);
    wr(4'd1, 8'h01);
    rd(4'd1, r); chk("R2 committed", r, 8'h01);
    chk("R2 mode_o", {7'b0, mode_o}, 8'h01);
    rd(4'd2, r); chk("R2 no error", r, 8'h00);

    wr(4'd1, 8'h00);
    rd(4'd1, r); chk("R6 relocked mode", r, 8'h01);
    rd(4'd2, r); chk("R6 relocked err", r, 8'h01);
    wr(4'd2, 8'h00);
    rd(4'd2, r); chk("R9 clear by zero", r, 8'h00);

    wr(4'd1, 8'h00);
    rd(4'd2, r); chk("R4 unarmed err", r, 8'h01);
    rd(4'd1, r); chk("R4 mode kept", r, 8'h01);
    wr(4'd2, 8'h00);

    wr(4'd0, 8'hA5); wr(4'd1, 8'h00); wr(4'd1, 8'h00);
    rd(4'd2, r); chk("R5 bad inverse err", r, 8'h01);
    wr(4'd2, 8'h00);
    wr(4'd1, 8'h01);
    rd(4'd2, r); chk("R5 attempt ended", r, 8'h01);
    wr(4'd2, 8'h00);
    wr(4'd0, 8'hA5); wr(4'd1, 8'h00); wr(4'd1, 8'h01); wr(4'd1, 8'h01);
    rd(4'd1, r); chk("R5 bad final mode", r, 8'h01);
    rd(4'd2, r); chk("R5 bad final err", r, 8'h01);
    wr(4'd2, 8'h00);

    wr(4'd0, 8'hA5); wr(4'd1, 8'h00); wr(4'd0, 8'hA5);
    wr(4'd1, 8'h00); wr(4'd1, 8'h01); wr(4'd1, 8'h00);
    rd(4'd1, r); chk("R7 restart commit", r, 8'h00);
    rd(4'd2, r); chk("R7 restart no err", r, 8'h00);
    wr(4'd0, 8'hA5); wr(4'd1, 8'h01); wr(4'd0, 8'h12);
    rd(4'd2, r); chk("R7 other key no err", r, 8'h00);
    wr(4'd1, 8'h01);
    rd(4'd2, r); chk("R7 other key dropped", r, 8'h01);
    wr(4'd2, 8'h00);

    pulse(1'b0, 1'b0);
    rd(4'd2, r); chk("R8 ext a", r, 8'h02);
    pulse(1'b1, 1'b0);
    rd(4'd2, r); chk("R8 ext b", r, 8'h06);
    wr(4'd2, 8'hFF);
    rd(4'd2, r); chk("R9 one keeps", r, 8'h06);
    wr(4'd2, 8'h04);
    rd(4'd2, r); chk("R9 selective clear", r, 8'h04);
    pulse(1'b0, 1'b1);
    rd(4'd2, r); chk("R9 set beats clear", r, 8'h02);
    wr(4'd2, 8'h00);

    rd(4'd0, r); chk("R10 key reads zero", r, 8'h00);
    wr(4'd0, 8'hA5); wr(4'd1, 8'h01); wr(4'd7, 8'h55); wr(4'd2, 8'hFF);
    wr(4'd1, 8'h00); wr(4'd1, 8'h01);
    rd(4'd1, r); chk("R10 side writes ignored", r, 8'h01);
    rd(4'd2, r); chk("R10 status upper zero", r, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule